// File: doc/BRIEF.md
# Host-Mapped Parallel Port with Strobe Capture and Interrupt

This block connects one 8-line bidirectional peripheral port to a microprocessor bus. The host reaches four registers through an 8-bit data bus, a two-bit register select and a read/write line. An access happens only when a pair of chip selects with opposite polarity are both asserted. The tri-state data bus and port pads are modelled as plain data vectors plus output-enable signals, so a pad ring or a parent module can build the real buffers.

Each port line is an input or an output, chosen bit by bit by a direction register. Output lines drive the value held in an output register. Input lines are read either live or from an input register that captures the pins on a programmable edge of a strobe line. The same edge sets an interrupt flag. An active-low interrupt request is driven to both levels from the flag ANDed with its enable.

All inputs are taken to be synchronous to `clk`. Writes take effect on the rising clock edge of the access cycle. Reads are combinational during that cycle. The host holds each access for exactly one clock.

Top module: `pport_top`

## Requirements
- R1: An access occurs only when `cs_hi` is 1 and `cs_lo_n` is 0 in the same cycle. With any other combination, writes change no register and `data_oe` stays 0.
- R2: During a selected read (`host_rd`=1), `data_oe` is 1 and `data_out` shows the addressed register in the same cycle. The addresses are: `rs`=0 port data, 1 direction, 2 flags, 3 interrupt enable.
- R3: During a selected write (`host_rd`=0), `data_in` is stored into the addressed register at the clock edge.
- R4: `port_oe[i]` equals direction bit i, where 1 means output and 0 means input. Any mix of directions is allowed.
- R5: `port_out` equals the output register, which is written at address 0.
- R6: A read of address 0 returns, bit by bit, the output register bit for output lines. For input lines it returns the captured input bit when capture is enabled, and the live `port_in` bit when it is not.
- R7: Interrupt enable bit 6 selects the active edge of `strb`: 1 selects rising and 0 selects falling. An active edge always sets flag bit 0. When enable-register bit 5 (capture enable) is 1, the same edge also loads `port_in` into the input register. An inactive edge does neither.
- R8: Flag bit 0 clears when the host writes a 1 to bit 0 of address 2, and on any selected read or write of address 0. If an active strobe edge arrives in the same cycle, the flag is set instead of cleared.
- R9: A write to address 3 with bit 7 set sets the bits marked 1 among bits 0, 5 and 6. With bit 7 clear, it clears them. A read of address 3 returns bit 7 as 1, bits 6, 5 and 0 as stored, and other bits as 0.
- R10: `irq_n` is 0 exactly when flag bit 0 and enable bit 0 are both 1, and is 1 otherwise. It is driven to both levels. Flag-register read bit 7 shows the request as 1 when it is active.
- R11: Reset clears every register: all lines are inputs, `port_out` is 0, `irq_n` is 1, and the enable register reads 8'h80.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_hi | input | 1 | Chip select, active high |
| cs_lo_n | input | 1 | Chip select, active low |
| host_rd | input | 1 | 1 = read, 0 = write |
| rs | input | 2 | Register select |
| data_in | input | 8 | Host write data |
| data_out | output | 8 | Host read data, 0 when not driven |
| data_oe | output | 1 | Data bus output enable |
| port_in | input | 8 | Port pin levels |
| port_out | output | 8 | Port output levels |
| port_oe | output | 8 | Per-line output enable |
| strb | input | 1 | Capture strobe |
| irq_n | output | 1 | Interrupt request, active low, push-pull |

## Verification
The assertions check several rules on every cycle. The bus must be released while the block is deselected. The line enables may change only after a direction write, and the output levels must follow an output-register write. The request must rise after its enable is cleared, and flag bit 7 must agree with `irq_n` on every flag read. The bench's scenarios cover the rest: the exhaustive direction sweep against mixed live pins, capture under both edge polarities with and without capture enabled, and the same-cycle race between a flag clear and a new edge.

// File: rtl/pport_pkg.sv
package pport_pkg;

    typedef enum logic [1:0] {
        RS_PORT = 2'd0,
        RS_DIR  = 2'd1,
        RS_FLAG = 2'd2,
        RS_IEN  = 2'd3
    } rs_e;

    typedef struct packed {
        logic flag;
        logic en;
        logic edge_pos;
        logic cap_en;
    } ctrl_t;

endpackage

// File: rtl/pport_edge.sv
module pport_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic strb,
    input  logic edge_pos,
    output logic hit
);
    typedef struct packed {
        logic strb_prev;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d           = st_q;
        st_d.strb_prev = strb;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hit = edge_pos ? (strb & ~st_q.strb_prev)
                          : (~strb & st_q.strb_prev);
endmodule

// File: rtl/pport_regfile.sv
module pport_regfile
    import pport_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel,
    input  logic          host_rd,
    input  logic [1:0]    rs,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] pins,
    input  logic          hit,
    output logic [DW-1:0] outr,
    output logic [DW-1:0] dir,
    output logic [DW-1:0] inr,
    output ctrl_t         ctrl
);
    localparam int SET_BIT = DW - 1;
    localparam int EDG_BIT = DW - 2;
    localparam int CAP_BIT = DW - 3;

    typedef struct packed {
        logic [DW-1:0] outr;
        logic [DW-1:0] dir;
        logic [DW-1:0] inr;
        ctrl_t         ctrl;
    } st_t;

    st_t  st_d, st_q;
    logic wr, port_acc;

    always_comb begin
        st_d     = st_q;
        wr       = sel & ~host_rd;
        port_acc = sel & (rs == RS_PORT);
        if (wr) begin
            unique case (rs_e'(rs))
                RS_PORT: st_d.outr = wdata;
                RS_DIR:  st_d.dir  = wdata;
                RS_FLAG: if (wdata[0]) st_d.ctrl.flag = 1'b0;
                RS_IEN: begin
                    if (wdata[0])       st_d.ctrl.en       = wdata[SET_BIT];
                    if (wdata[EDG_BIT]) st_d.ctrl.edge_pos = wdata[SET_BIT];
                    if (wdata[CAP_BIT]) st_d.ctrl.cap_en   = wdata[SET_BIT];
                end
                default: ;
            endcase
        end
        if (port_acc) st_d.ctrl.flag = 1'b0;
        if (hit) begin
            st_d.ctrl.flag = 1'b1;
            if (st_q.ctrl.cap_en) st_d.inr = pins;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign outr = st_q.outr;
    assign dir  = st_q.dir;
    assign inr  = st_q.inr;
    assign ctrl = st_q.ctrl;
endmodule

// File: rtl/pport_rdmux.sv
module pport_rdmux
    import pport_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [1:0]    rs,
    input  logic [DW-1:0] outr,
    input  logic [DW-1:0] dir,
    input  logic [DW-1:0] inr,
    input  logic [DW-1:0] pins,
    input  ctrl_t         ctrl,
    output logic [DW-1:0] rdata
);
    localparam int EDG_BIT = DW - 2;
    localparam int CAP_BIT = DW - 3;

    logic [DW-1:0] port_val, flag_val, ien_val;

    for (genvar i = 0; i < DW; i++) begin : g_bit
        always_comb begin
            if (dir[i])           port_val[i] = outr[i];
            else if (ctrl.cap_en) port_val[i] = inr[i];
            else                  port_val[i] = pins[i];
        end
    end

    always_comb begin
        flag_val          = '0;
        flag_val[0]       = ctrl.flag;
        flag_val[DW-1]    = ctrl.flag & ctrl.en;
        ien_val           = '0;
        ien_val[0]        = ctrl.en;
        ien_val[EDG_BIT]  = ctrl.edge_pos;
        ien_val[CAP_BIT]  = ctrl.cap_en;
        ien_val[DW-1]     = 1'b1;
        unique case (rs_e'(rs))
            RS_PORT: rdata = port_val;
            RS_DIR:  rdata = dir;
            RS_FLAG: rdata = flag_val;
            RS_IEN:  rdata = ien_val;
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/pport_top.sv
module pport_top
    import pport_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_hi,
    input  logic          cs_lo_n,
    input  logic          host_rd,
    input  logic [1:0]    rs,
    input  logic [DW-1:0] data_in,
    output logic [DW-1:0] data_out,
    output logic          data_oe,
    input  logic [DW-1:0] port_in,
    output logic [DW-1:0] port_out,
    output logic [DW-1:0] port_oe,
    input  logic          strb,
    output logic          irq_n
);
    logic          sel, hit;
    logic [DW-1:0] outr, dir, inr, rdata;
    ctrl_t         ctrl;

    assign sel = cs_hi & ~cs_lo_n;

    pport_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .strb     (strb),
        .edge_pos (ctrl.edge_pos),
        .hit      (hit)
    );

    pport_regfile #(.DW(DW)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (sel),
        .host_rd (host_rd),
        .rs      (rs),
        .wdata   (data_in),
        .pins    (port_in),
        .hit     (hit),
        .outr    (outr),
        .dir     (dir),
        .inr     (inr),
        .ctrl    (ctrl)
    );

    pport_rdmux #(.DW(DW)) u_rdmux (
        .rs    (rs),
        .outr  (outr),
        .dir   (dir),
        .inr   (inr),
        .pins  (port_in),
        .ctrl  (ctrl),
        .rdata (rdata)
    );

    assign data_oe  = sel & host_rd;
    assign data_out = data_oe ? rdata : '0;
    assign port_out = outr;
    assign port_oe  = dir;
    assign irq_n    = ~(ctrl.flag & ctrl.en);
endmodule

// File: rtl/pport_chk.sv
module pport_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cs_hi,
    input logic          cs_lo_n,
    input logic          host_rd,
    input logic [1:0]    rs,
    input logic [DW-1:0] data_in,
    input logic [DW-1:0] data_out,
    input logic          data_oe,
    input logic [DW-1:0] port_out,
    input logic [DW-1:0] port_oe,
    input logic          irq_n
);
    logic acc_wr;
    assign acc_wr = cs_hi && !cs_lo_n && !host_rd;

    p_desel_hiz_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(cs_hi && !cs_lo_n) |-> !data_oe);

    p_dir_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(acc_wr && rs == 2'd1) |-> port_oe == $past(data_in));

    p_dir_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(acc_wr && rs == 2'd1) |-> $stable(port_oe));

    p_out_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(acc_wr && rs == 2'd0) |-> port_out == $past(data_in));

    p_ien_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(acc_wr && rs == 2'd3 && !data_in[DW-1] && data_in[0]) |-> irq_n);

    p_flag_mirror_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (data_oe && rs == 2'd2) |-> data_out[DW-1] == !irq_n);

    always @(posedge clk) begin
        if (!rst_n) begin
            p_reset_r11: assert (port_oe == '0 && port_out == '0 && irq_n);
        end
    end
endmodule

bind pport_top pport_chk #(.DW(DW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_hi    (cs_hi),
    .cs_lo_n  (cs_lo_n),
    .host_rd  (host_rd),
    .rs       (rs),
    .data_in  (data_in),
    .data_out (data_out),
    .data_oe  (data_oe),
    .port_out (port_out),
    .port_oe  (port_oe),
    .irq_n    (irq_n)
);

// File: tb/pport_top_bench.sv
module pport_top_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_hi = 1'b0;
    logic       cs_lo_n = 1'b1;
    logic       host_rd = 1'b1;
    logic [1:0] rs = 2'd0;
    logic [7:0] data_in = 8'h00;
    logic [7:0] data_out;
    logic       data_oe;
    logic [7:0] port_in = 8'h00;
    logic [7:0] port_out;
    logic [7:0] port_oe;
    logic       strb = 1'b0;
    logic       irq_n;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pport_top u_pport_top (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_hi    (cs_hi),
        .cs_lo_n  (cs_lo_n),
        .host_rd  (host_rd),
        .rs       (rs),
        .data_in  (data_in),
        .data_out (data_out),
        .data_oe  (data_oe),
        .port_in  (port_in),
        .port_out (port_out),
        .port_oe  (port_oe),
        .strb     (strb),
        .irq_n    (irq_n)
    );

    task automatic check(input logic ok, input string req, input logic [7:0] act,
                         input logic [7:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic deselect();
        cs_hi = 1'b0; cs_lo_n = 1'b1; host_rd = 1'b1;
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
        cs_hi = 1'b1; cs_lo_n = 1'b0; host_rd = 1'b0; rs = a; data_in = d;
        @(posedge clk); @(negedge clk);
        deselect();
    endtask

    task automatic bus_rd(input logic [1:0] a, output logic [7:0] d, output logic oe);
        cs_hi = 1'b1; cs_lo_n = 1'b0; host_rd = 1'b1; rs = a;
        #1;
        d = data_out; oe = data_oe;
        @(posedge clk); @(negedge clk);
        deselect();
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: actual %02h expected %02h", 8'h01, 8'h00);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] rd;
        logic       oe;
        logic [7:0] exp;

        repeat (3) @(negedge clk);
        check(port_oe == 8'h00, "R11 port_oe", port_oe, 8'h00);
        check(port_out == 8'h00, "R11 port_out", port_out, 8'h00);
        check(irq_n == 1'b1, "R11 irq_n", {7'd0, irq_n}, 8'h01);
        rst_n = 1'b1;
        @(negedge clk);
        bus_rd(2'd3, rd, oe);
        check(rd == 8'h80, "R11 enable reg", rd, 8'h80);
        bus_rd(2'd1, rd, oe);
        check(rd == 8'h00 && oe, "R11 dir reg", rd, 8'h00);

        // R1: only cs_hi=1, cs_lo_n=0 selects
        for (int k = 0; k < 4; k++) begin
            bus_wr(2'd1, 8'h00);
            cs_hi = k[1]; cs_lo_n = k[0]; host_rd = 1'b0; rs = 2'd1; data_in = 8'hFF;
            @(posedge clk); @(negedge clk);
            host_rd = 1'b1;
            #1;
            exp = (k == 2) ? 8'h01 : 8'h00;
            check(data_oe == exp[0], "R1 data_oe", {7'd0, data_oe}, exp);
            deselect();
            bus_rd(2'd1, rd, oe);
            exp = (k == 2) ? 8'hFF : 8'h00;
            check(rd == exp, "R1 write gating", rd, exp);
        end

        // R5: output register sweep
        for (int j = 0; j < 256; j++) begin
            bus_wr(2'd0, j[7:0]);
            check(port_out == j[7:0], "R5 port_out", port_out, j[7:0]);
        end

        // R4/R6/R2: direction sweep with live pins
        bus_wr(2'd0, 8'hC3);
        port_in = 8'h5A;
        for (int i = 0; i < 256; i++) begin
            bus_wr(2'd1, i[7:0]);
            check(port_oe == i[7:0], "R4 port_oe", port_oe, i[7:0]);
            bus_rd(2'd0, rd, oe);
            exp = (i[7:0] & 8'hC3) | (~i[7:0] & 8'h5A);
            check(rd == exp && oe, "R6 R2 mixed read", rd, exp);
        end
        bus_wr(2'd1, 8'h00);

        // R7/R8: edge polarity x capture enable
        for (int e = 0; e < 2; e++) begin
            for (int l = 0; l < 2; l++) begin
                strb = (e == 0);
                repeat (2) @(negedge clk);
                bus_wr(2'd3, 8'h7F);
                bus_wr(2'd3, {1'b1, e[0], l[0], 5'b0});
                bus_wr(2'd2, 8'h01);
                bus_rd(2'd2, rd, oe);
                check(rd[0] == 1'b0, "R8 flag cleared by write", rd, 8'h00);
                port_in = 8'hA5;
                strb = ~strb;
                @(negedge clk);
                port_in = 8'h3C;
                bus_rd(2'd2, rd, oe);
                check(rd[0] == 1'b1, "R7 active edge sets flag", rd, 8'h01);
                bus_rd(2'd0, rd, oe);
                exp = l ? 8'hA5 : 8'h3C;
                check(rd == exp, "R7 capture", rd, exp);
                bus_rd(2'd2, rd, oe);
                check(rd[0] == 1'b0, "R8 port read clears flag", rd, 8'h00);
                strb = ~strb;
                repeat (2) @(negedge clk);
                bus_rd(2'd2, rd, oe);
                check(rd[0] == 1'b0, "R7 inactive edge ignored", rd, 8'h00);
                bus_rd(2'd0, rd, oe);
                exp = l ? 8'hA5 : 8'h3C;
                check(rd == exp, "R7 no capture on inactive edge", rd, exp);
            end
        end

        // R8: edge wins over same-cycle clear; bit0=0 write keeps flag
        bus_wr(2'd3, 8'h7F);
        bus_wr(2'd3, 8'hC0);
        strb = 1'b0;
        repeat (2) @(negedge clk);
        bus_wr(2'd2, 8'h01);
        strb = 1'b1;
        bus_wr(2'd2, 8'h01);
        bus_rd(2'd2, rd, oe);
        check(rd[0] == 1'b1, "R8 edge beats clear", rd, 8'h01);
        bus_wr(2'd2, 8'h80);
        bus_rd(2'd2, rd, oe);
        check(rd[0] == 1'b1, "R8 write of 0 keeps flag", rd, 8'h01);

        // R10: request from flag AND enable
        check(irq_n == 1'b1, "R10 disabled", {7'd0, irq_n}, 8'h01);
        bus_wr(2'd3, 8'h81);
        check(irq_n == 1'b0, "R10 asserted", {7'd0, irq_n}, 8'h00);
        bus_rd(2'd2, rd, oe);
        check(rd == 8'h81, "R10 flag bit7", rd, 8'h81);
        bus_wr(2'd3, 8'h01);
        check(irq_n == 1'b1, "R10 enable cleared", {7'd0, irq_n}, 8'h01);
        bus_wr(2'd3, 8'h81);
        bus_wr(2'd2, 8'h01);
        check(irq_n == 1'b1, "R10 flag cleared", {7'd0, irq_n}, 8'h01);

        // R9: set/clear semantics
        bus_wr(2'd3, 8'h7F);
        bus_rd(2'd3, rd, oe);
        check(rd == 8'h80, "R9 clear all", rd, 8'h80);
        bus_wr(2'd3, 8'hFF);
        bus_rd(2'd3, rd, oe);
        check(rd == 8'hE1, "R9 set all", rd, 8'hE1);
        bus_wr(2'd3, 8'h40);
        bus_rd(2'd3, rd, oe);
        check(rd == 8'hA1, "R9 clear one", rd, 8'hA1);

        // R3: write then read every plain register
        bus_wr(2'd1, 8'h96);
        bus_rd(2'd1, rd, oe);
        check(rd == 8'h96, "R3 dir write", rd, 8'h96);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule